// File: doc/BRIEF.md
# Instrument Status and Service-Request Logic

This block gathers instrument status into a small set of register groups and turns it into one service-request line for a host controller. One group, the standard event group, takes only single-cycle event pulses. Each of the other groups watches a vector of live condition inputs and records each rising edge. In every group the recorded events are sticky. They are masked by an enable register that software can write, and the result is reduced to one summary bit.

The summary bits form a status byte that is built live from the registers and is never latched. A second mask, the service-request enable register, selects which summary bits raise the master-summary bit. That bit appears in the status byte and drives the service-request output. Software reaches all registers through a simple register bus. Reading a group's event register returns its contents and clears it. A clear-all input empties every event register at once.

Top module: `stat_srq_core`

## Requirements
- R1: After reset every event, enable and service-request enable register reads 0, and `srq_o` is low.
- R2: Reading offset 0 of a condition-backed group returns the present value of its condition inputs. Offset 0 of the standard event group always reads 0.
- R3: A condition-backed event bit sets in the cycle after its condition input is high while it was low in the previous cycle. Before the first cycle after reset, the previous value counts as 0. A condition that stays high does not set the bit again.
- R4: A bit of `std_evt_i` that is high for one cycle sets the matching bit of the standard event register.
- R5: An event bit that is set stays set. A further event on that bit changes nothing until a read or a clear-all clears it.
- R6: A read at offset 1 of a group returns the event register value from before the clear, and then clears the register. An event that arrives in the same cycle as the read is still set for the next read.
- R7: Each enable register at offset 2 can be written and read back. Writes to condition, event and status-byte addresses leave every register unchanged.
- R8: A group's summary bit is the OR of (event AND enable), taken live from the registers. Condition group k (counting from 0) places its summary at status-byte bit k. The standard event group places its summary at bit 5. Bit 7 reads 0.
- R9: The service-request enable register at address 0x3F can be written and read back. Status-byte bit 6 is the master summary: the OR of (status byte AND service-request enable) with bit 6 excluded. `srq_o` equals that bit.
- R10: Clear-all empties every event register and leaves the enable and service-request enable registers unchanged. An event that arrives in the same cycle as the clear-all is kept.
- R11: Address map: group s (s=0 is the standard event group, s=1.. are the condition groups) has base 4*s. The status byte is at 0x3E. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe; clears the event register it addresses |
| rd_data_o | output | DATA_W | Read data, combinational from `addr_i` |
| clr_all_i | input | 1 | Clear every event register |
| std_evt_i | input | DATA_W | Event pulses for the standard event group |
| cond_i | input | NUM_COND*DATA_W | Live condition inputs, group 1 in the low bits |
| srq_o | output | 1 | Service-request line (master summary) |

## Verification
The bench targets the cycle in which a read and a new event coincide. A design that lets the clear win would lose that event, and the bench sees the second read come back empty. It holds a condition high across a read-clear: a level-sensitive event path would set the bit again at once, where only a fresh edge should. It sweeps every service-request enable value against several status-byte patterns. A mask that let bit 6 feed back, or that placed a summary bit in the wrong position, would raise or drop `srq_o` in the wrong place. A clear-all is issued in the same cycle as an event pulse, and the bench then checks that the enables were kept.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STB_W       = 8;
  localparam int MSS_BIT     = 6;
  localparam int STD_SUM_BIT = 5;
  localparam int SET_STRIDE  = 4;
  localparam int OFS_COND    = 0;
  localparam int OFS_EVT     = 1;
  localparam int OFS_EN      = 2;

  // Status-byte position of the summary bit of group s
  function automatic int sum_pos(int s);
    return (s == 0) ? STD_SUM_BIT : s - 1;
  endfunction

  // Master summary: enabled status bits, with the master bit itself excluded
  function automatic logic mss_of(logic [STB_W-1:0] stb, logic [STB_W-1:0] sre);
    logic [STB_W-1:0] m;
    m = stb & sre;
    m[MSS_BIT] = 1'b0;
    return |m;
  endfunction
endpackage

// File: rtl/stat_evset.sv
module stat_evset #(
  parameter int W        = 8,
  parameter bit HAS_COND = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] pulse_i,
  input  logic         clr_all_i,
  input  logic         rd_clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wd_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] event_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] set_o,
  output logic         summary_o
);
  function automatic logic [W-1:0] rise_of(logic [W-1:0] now, logic [W-1:0] prev);
    return now & ~prev;
  endfunction

  function automatic logic reduce_sum(logic [W-1:0] ev, logic [W-1:0] en);
    return |(ev & en);
  endfunction

  logic [W-1:0] ev_q, en_q;

  if (HAS_COND) begin : g_cond
    logic [W-1:0] cond_q;
    logic         unused_pulse;
    assign unused_pulse = ^pulse_i;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) cond_q <= '0;
      else         cond_q <= cond_i;
    end
    assign set_o  = rise_of(cond_i, cond_q);
    assign cond_o = cond_i;
  end else begin : g_pulse
    logic unused_cond;
    assign unused_cond = ^cond_i;
    assign set_o  = pulse_i;
    assign cond_o = '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= ((clr_all_i || rd_clr_i) ? '0 : ev_q) | set_o;
      if (en_we_i) en_q <= en_wd_i;
    end
  end

  assign event_o   = ev_q;
  assign enable_o  = en_q;
  assign summary_o = reduce_sum(ev_q, en_q);
endmodule

// File: rtl/stat_req_gen.sv
module stat_req_gen import stat_pkg::*; #(
  parameter int NSETS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSETS-1:0] sum_i,
  input  logic             sre_we_i,
  input  logic [STB_W-1:0] sre_wd_i,
  output logic [STB_W-1:0] stb_o,
  output logic [STB_W-1:0] sre_o,
  output logic             mss_o
);
  logic [STB_W-1:0] sre_q, base;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       sre_q <= '0;
    else if (sre_we_i) sre_q <= sre_wd_i;
  end

  always_comb begin
    base = '0;
    for (int s = 0; s < NSETS; s++) base[3'(sum_pos(s))] = sum_i[s];
    mss_o = mss_of(base, sre_q);
    stb_o = base;
    stb_o[MSS_BIT] = mss_o;
  end

  assign sre_o = sre_q;
endmodule

// File: rtl/stat_srq_core.sv
module stat_srq_core import stat_pkg::*; #(
  parameter int NUM_COND = 2,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int STB_ADDR = 62,
  parameter int SRE_ADDR = 63
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_en_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     rd_en_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     clr_all_i,
  input  logic [DATA_W-1:0]        std_evt_i,
  input  logic [NUM_COND*DATA_W-1:0] cond_i,
  output logic                     srq_o
);
  localparam int NSETS = NUM_COND + 1;

  logic [NSETS*DATA_W-1:0] ev_all, en_all, set_all, cnd_all;
  logic [NSETS*DATA_W-1:0] cond_src, pulse_src;
  logic [NSETS-1:0]        sum_all, rdclr_all, enwe_all;
  logic [STB_W-1:0]        stb_w, sre_w;
  logic                    mss_w, sre_we;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    localparam int BASE = s * SET_STRIDE;
    if (s == 0) begin : g_std
      assign cond_src[s*DATA_W +: DATA_W]  = '0;
      assign pulse_src[s*DATA_W +: DATA_W] = std_evt_i;
    end else begin : g_cnd
      assign cond_src[s*DATA_W +: DATA_W]  = cond_i[(s-1)*DATA_W +: DATA_W];
      assign pulse_src[s*DATA_W +: DATA_W] = '0;
    end
    assign rdclr_all[s] = rd_en_i && (addr_i == ADDR_W'(BASE + OFS_EVT));
    assign enwe_all[s]  = wr_en_i && (addr_i == ADDR_W'(BASE + OFS_EN));

    stat_evset #(.W(DATA_W), .HAS_COND(s != 0)) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cond_i    (cond_src[s*DATA_W +: DATA_W]),
      .pulse_i   (pulse_src[s*DATA_W +: DATA_W]),
      .clr_all_i (clr_all_i),
      .rd_clr_i  (rdclr_all[s]),
      .en_we_i   (enwe_all[s]),
      .en_wd_i   (wr_data_i),
      .cond_o    (cnd_all[s*DATA_W +: DATA_W]),
      .event_o   (ev_all[s*DATA_W +: DATA_W]),
      .enable_o  (en_all[s*DATA_W +: DATA_W]),
      .set_o     (set_all[s*DATA_W +: DATA_W]),
      .summary_o (sum_all[s])
    );
  end

  assign sre_we = wr_en_i && (addr_i == ADDR_W'(SRE_ADDR));

  stat_req_gen #(.NSETS(NSETS)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sum_i    (sum_all),
    .sre_we_i (sre_we),
    .sre_wd_i (wr_data_i[STB_W-1:0]),
    .stb_o    (stb_w),
    .sre_o    (sre_w),
    .mss_o    (mss_w)
  );

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(STB_ADDR)) rd_data_o = DATA_W'(stb_w);
    if (addr_i == ADDR_W'(SRE_ADDR)) rd_data_o = DATA_W'(sre_w);
    for (int s = 0; s < NSETS; s++) begin
      if (addr_i == ADDR_W'(s*SET_STRIDE + OFS_COND)) rd_data_o = cnd_all[s*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(s*SET_STRIDE + OFS_EVT))  rd_data_o = ev_all[s*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(s*SET_STRIDE + OFS_EN))   rd_data_o = en_all[s*DATA_W +: DATA_W];
    end
  end

  assign srq_o = mss_w;
endmodule

// File: rtl/stat_srq_chk.sv
module stat_srq_chk #(
  parameter int NSETS  = 3,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_all,
  input logic                    wr_en,
  input logic                    srq,
  input logic [7:0]              stb,
  input logic [7:0]              sre,
  input logic [NSETS*DATA_W-1:0] ev_all,
  input logic [NSETS*DATA_W-1:0] set_all,
  input logic [NSETS*DATA_W-1:0] en_all,
  input logic [NSETS-1:0]        rdclr
);
  AST_MSS_IN_STB: assert property (@(posedge clk) disable iff (!rst_n) stb[6] == srq); // R9
  AST_SRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> ((stb & sre & 8'hBF) != 8'h00)); // R9
  AST_QUIET_NO_SRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb & 8'hBF) == 8'h00) |-> !srq); // R9
  AST_STB_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !stb[7]); // R8
  AST_CLR_KEEPS_SRE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wr_en) |=> $stable(sre)); // R10

  for (genvar s = 0; s < NSETS; s++) begin : g_chk
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all && !rdclr[s]) |=>
      ((ev_all[s*DATA_W +: DATA_W] & $past(ev_all[s*DATA_W +: DATA_W])) ==
       $past(ev_all[s*DATA_W +: DATA_W]))); // R5
    AST_EVT_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((ev_all[s*DATA_W +: DATA_W] & ~$past(ev_all[s*DATA_W +: DATA_W]) &
                  ~$past(set_all[s*DATA_W +: DATA_W])) == '0)); // R3
    AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (ev_all[s*DATA_W +: DATA_W] == $past(set_all[s*DATA_W +: DATA_W]))); // R10
    AST_CLR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !wr_en) |=> $stable(en_all[s*DATA_W +: DATA_W])); // R10
  end
endmodule

bind stat_srq_core stat_srq_chk #(.NSETS(NSETS), .DATA_W(DATA_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .clr_all (clr_all_i),
  .wr_en   (wr_en_i),
  .srq     (srq_o),
  .stb     (stb_w),
  .sre     (sre_w),
  .ev_all  (ev_all),
  .set_all (set_all),
  .en_all  (en_all),
  .rdclr   (rdclr_all)
);

// File: tb/test_stat_srq_core.sv
`timescale 1ns/1ps
module test_stat_srq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, clr_all = 1'b0;
  logic [7:0]  wr_data = '0, std_evt = '0;
  logic [15:0] cond_d = '0;
  logic [7:0]  rd_data;
  logic        srq;
  int          n_chk = 0, n_fail = 0;

  logic [7:0] ev_m[3], en_m[3], prev_m[3], sre_m;

  always #2.5 clk = ~clk;

  stat_srq_core i_stat_srq_core (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .clr_all_i(clr_all), .std_evt_i(std_evt),
    .cond_i(cond_d), .srq_o(srq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stb();
    logic [7:0] b = '0;
    for (int s = 0; s < 3; s++)
      if ((ev_m[s] & en_m[s]) != 0) b[(s == 0) ? 5 : s - 1] = 1'b1;
    b[6] = ((b & sre_m & 8'hBF) != 0);
    return b;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (a == 62) return exp_stb();
    if (a == 63) return sre_m;
    if (a / 4 < 3) begin
      case (a % 4)
        0: return (a / 4 == 0) ? 8'h00 : cond_d[(a/4-1)*8 +: 8];
        1: return ev_m[a/4];
        2: return en_m[a/4];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  task automatic cyc();
    logic [7:0] nev[3], nen[3], nsre, setv;
    for (int s = 0; s < 3; s++) begin
      setv = (s == 0) ? std_evt : (cond_d[(s-1)*8 +: 8] & ~prev_m[s]);
      nev[s] = ((clr_all || (rd_en && addr == 6'(4*s+1))) ? 8'h00 : ev_m[s]) | setv;
      nen[s] = (wr_en && addr == 6'(4*s+2)) ? wr_data : en_m[s];
    end
    nsre = (wr_en && addr == 6'd63) ? wr_data : sre_m;
    @(posedge clk);
    for (int s = 0; s < 3; s++) begin
      ev_m[s] = nev[s];
      en_m[s] = nen[s];
      prev_m[s] = (s == 0) ? 8'h00 : cond_d[(s-1)*8 +: 8];
    end
    sre_m = nsre;
    @(negedge clk);
    wr_en = 0; rd_en = 0; clr_all = 0; std_evt = '0;
  endtask

  task automatic rd(int a, string tag);
    addr = 6'(a); rd_en = 1'b1;
    #1 chk(tag, rd_data, exp_rd(a));
    cyc();
  endtask

  task automatic wr(int a, logic [7:0] d);
    addr = 6'(a); wr_en = 1'b1; wr_data = d;
    cyc();
  endtask

  task automatic srq_chk(string tag);
    #1 chk(tag, srq, exp_stb()[6]);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) begin ev_m[s] = 0; en_m[s] = 0; prev_m[s] = 0; end
    sre_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R11: every address reads 0 out of reset
    srq_chk("R1 srq after reset");
    for (int a = 0; a < 64; a++) rd(a, "R1 R11 reset read");

    // R7: enable registers and read-only addresses
    for (int s = 0; s < 3; s++) begin
      wr(4*s+2, 8'hA5 ^ 8'(s));
      rd(4*s+2, "R7 enable readback");
      wr(4*s+1, 8'hFF);
      wr(4*s, 8'hFF);
    end
    wr(62, 8'hFF);
    for (int a = 0; a < 64; a++) rd(a, "R7 R11 read-only writes ignored");
    for (int s = 0; s < 3; s++) wr(4*s+2, 8'h00);

    // R4 R5: pulses and stickiness
    std_evt = 8'h05; cyc();
    std_evt = 8'h04; cyc();
    rd(1, "R4 R5 std event sticky");
    rd(1, "R6 cleared after read");
    rd(0, "R2 std group condition reads 0");

    // R2 R3: condition edges
    cond_d = 16'h003C; cyc();
    rd(4, "R2 live condition");
    rd(5, "R3 rising edge sets");
    cyc();
    rd(5, "R3 held condition does not re-set");
    cond_d = 16'h000C; cyc();
    cond_d = 16'h003C; cyc();
    rd(5, "R3 new edge sets only fresh bits");
    for (int b = 0; b < 8; b++) begin
      cond_d = 16'(1 << (b + 8)); cyc();
      rd(8, "R2 live condition group 2");
      rd(9, "R3 sweep edge");
      cond_d = 16'h0000; cyc();
      rd(9, "R3 falling edge sets nothing");
    end

    // R6: event in the same cycle as the read
    std_evt = 8'h01; cyc();
    addr = 6'd1; rd_en = 1'b1; std_evt = 8'h80;
    #1 chk("R6 read returns pre-clear value", rd_data, 8'h01);
    cyc();
    rd(1, "R6 same-cycle event kept");

    // R8: summary placement, bit by bit in every group
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 8; b++) begin
        wr(4*s+2, 8'(1 << ((b + 1) % 8)));
        if (s == 0) begin std_evt = 8'(1 << b); cyc(); end
        else begin cond_d = 16'(1 << ((s-1)*8 + b)); cyc(); end
        rd(62, "R8 summary off when enable elsewhere");
        wr(4*s+2, 8'(1 << b));
        rd(62, "R8 summary on in its position");
        rd(4*s+1, "R8 event clear");
        rd(62, "R8 summary drops after clear");
        cond_d = '0; cyc();
        wr(4*s+2, 8'h00);
      end

    // R9: service-request enable sweep over several status patterns
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 3; s++) wr(4*s+2, 8'hFF);
      if (p[0]) begin std_evt = 8'h10; cyc(); end
      if (p[1]) begin cond_d = 16'h0200; cyc(); end
      if (p == 0) begin cond_d = 16'h0001; cyc(); end
      for (int v = 0; v < 256; v++) begin
        wr(63, 8'(v));
        srq_chk("R9 srq vs enable mask");
        rd(62, "R9 status byte master bit");
      end
      rd(63, "R9 sre readback");
      rd(1, "R9 clear"); rd(5, "R9 clear"); rd(9, "R9 clear");
      cond_d = '0; cyc();
    end

    // R10: clear-all with a same-cycle event
    wr(63, 8'h27);
    for (int s = 0; s < 3; s++) wr(4*s+2, 8'h3C + 8'(s));
    std_evt = 8'h40; cyc();
    cond_d = 16'hFFFF; cyc();
    clr_all = 1'b1; std_evt = 8'h02; cyc();
    for (int a = 0; a < 12; a++) rd(a, "R10 clear-all result");
    rd(63, "R10 sre kept");
    srq_chk("R10 srq after clear-all");
    for (int a = 0; a < 64; a++) rd(a, "R11 final map sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule